// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synchronous single-port memory with a small parameterised depth and byte-lane writes, fronted by the cycle logic of a burst cache SRAM. A burst opens on one of two address strobes. The processor strobe always opens with a read. The controller strobe samples the write enables on its own edge. Further beats run from an internal burst counter that steps in either a linear or an interleaved order.

Writes are decided per lane. A global write input overrides the per-lane controls. Otherwise a lane gate plus a per-lane enable selects which lanes are written. Read data goes through a registered output stage. A flow-through input bypasses that stage, which saves one cycle of latency. The output is qualified by an asynchronous output enable, a valid flag and a snooze input. When the output is not valid, the data bus reads as zero, the way a released tristate bus would.

Top module: `burst_sram_ctrl`

## Requirements
- R1: At an edge that opens a burst with the controller strobe, or at a continue beat, `write_all_n` low writes every lane at the beat address, whatever `lane_gate_n` and `lane_en_n` are.
- R2: With `write_all_n` high and `lane_gate_n` low, lane i (data bits `[i*LANE_W +: LANE_W]`, lane 0 in the low bits) is written only when `lane_en_n[i]` is 0. If no lane enable is 0, the beat is a read.
- R3: With `write_all_n` and `lane_gate_n` both high, the beat is a read and no lane changes.
- R4: An edge where `proc_strobe_n` is low, with `master_sel_n` low and `aux_sel` high, loads `addr` and is always a read; the write inputs are ignored on that edge. On the following continue beats the lane controls are sampled again and can write.
- R5: The controller strobe opens a burst only when `proc_strobe_n` is high. Its write inputs are sampled on that same edge, and a write goes to the loaded address. If both strobes are low, the processor strobe wins and the beat is a read.
- R6: With `flow_thru_n` high, data read at edge k is valid on `rdata` only after edge k+1. After edge k, `rdata_vld` is still low.
- R7: With `flow_thru_n` low, data read at edge k is valid on `rdata` right after edge k.
- R8: A continue beat (both strobes high, burst open) with `burst_step_n` low first steps the low 2 address bits, then reads or writes there. With `linear_mode`=1 the low bits are (start+n) mod 4. With `linear_mode`=0 they are start XOR n. The upper bits never change. With `burst_step_n` high the beat repeats at the current address.
- R9: `rdata_vld` is high only while `out_en_n` is low. `rdata` is 0 whenever `rdata_vld` is low. In the cycle after any write beat, `rdata_vld` is low whatever `out_en_n` is.
- R10: A strobe edge with the enables inactive (deselect) closes the burst. `rdata_vld` drops after that edge in flow-through mode, or one edge later in pipelined mode. `master_sel_n` high blocks the processor strobe, so that edge changes nothing, but it does not block the controller strobe, which then deselects.
- R11: While `snooze` is high, no edge loads, writes or reads, `rdata_vld` is low, and memory contents are kept.
- R12: During and after reset, `rdata_vld` is low and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Start address of a burst |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| master_sel_n | input | 1 | Master chip enable, active low |
| aux_sel | input | 1 | Secondary chip enable, active high |
| burst_step_n | input | 1 | Burst advance, active low |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| write_all_n | input | 1 | Global write of all lanes, active low |
| lane_gate_n | input | 1 | Enables per-lane write selects, active low |
| lane_en_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| flow_thru_n | input | 1 | 0 = bypass output register |
| snooze | input | 1 | Blocks all accesses while high |
| rdata | output | LANES*LANE_W | Read data, 0 when not valid |
| rdata_vld | output | 1 | Output driven and valid |

## Verification
The hardest situations to reach are the beats that depend on an open burst: a processor-strobe read followed by a byte write at the same address, a pipelined deselect that still drains one beat, and a blocked processor strobe in the middle of a burst. The stimulus first closes any burst with a deselect. It then opens a fresh one and holds the output enable low only in the cycles of interest. Because of this, each valid output pairs with exactly one scoreboard entry, and any extra, missing or late output shows up as a mismatch.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  // What a rising edge does to the burst state.
  typedef enum logic [1:0] {
    EDGE_IDLE  = 2'd0,
    EDGE_LOAD  = 2'd1,
    EDGE_CONT  = 2'd2,
    EDGE_DESEL = 2'd3
  } edge_kind_t;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int LANES = 2
) (
  input  logic             write_all_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_en_n,
  output logic [LANES-1:0] lane_we,
  output logic             any_we
);
  // The global write overrides the gated per-lane selects.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = !write_all_n || (!lane_gate_n && !lane_en_n[g]);
  end
  assign any_we = |lane_we;
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int ADDR_W     = 6,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              linear,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [HI_W-1:0]       hi_q;
  logic [BURST_BITS-1:0] base_q;
  logic [BURST_BITS-1:0] cnt_q;
  logic [BURST_BITS-1:0] cnt_nxt;

  function automatic logic [BURST_BITS-1:0] beat_lo(
    input logic [BURST_BITS-1:0] b,
    input logic [BURST_BITS-1:0] c,
    input logic lin);
    return lin ? (b + c) : (b ^ c);
  endfunction

  assign cnt_nxt  = cnt_q + 1'b1;
  assign cur_addr = {hi_q, beat_lo(base_q, cnt_q, linear)};
  assign nxt_addr = {hi_q, beat_lo(base_q, cnt_nxt, linear)};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      hi_q   <= load_addr[ADDR_W-1:BURST_BITS];
      base_q <= load_addr[BURST_BITS-1:0];
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_nxt;
    end
  end

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cur_addr[ADDR_W-1:BURST_BITS] == $past(cur_addr[ADDR_W-1:BURST_BITS]))); // R8
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // One inferable RAM per lane: byte write, synchronous read.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)      rd_q      <= mem[addr];
    end
    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 2,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    master_sel_n,
  input  logic                    aux_sel,
  input  logic                    burst_step_n,
  input  logic                    linear_mode,
  input  logic                    write_all_n,
  input  logic                    lane_gate_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  input  logic                    flow_thru_n,
  input  logic                    snooze,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_vld
);
  localparam int DATA_W = LANES * LANE_W;

  logic              active_q, vld1_q, vld2_q, wr_hide_q;
  logic [DATA_W-1:0] out_q, ram_q, sel_data;
  logic              proc_go, ctrl_go, sel_ok, sel_vld;
  edge_kind_t        kind;
  logic [LANES-1:0]  lane_we, mem_we;
  logic              any_we, wr_beat, rd_beat, step;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, eff_addr;

  // Edge classification: processor strobe is blocked by the master enable,
  // controller strobe needs the processor strobe high.
  always_comb begin
    proc_go = !snooze && !proc_strobe_n && !master_sel_n;
    ctrl_go = !snooze && proc_strobe_n && !ctrl_strobe_n;
    sel_ok  = proc_go ? aux_sel : (!master_sel_n && aux_sel);
    kind    = EDGE_IDLE;
    if (proc_go || ctrl_go)
      kind = sel_ok ? EDGE_LOAD : EDGE_DESEL;
    else if (!snooze && proc_strobe_n && ctrl_strobe_n && active_q)
      kind = EDGE_CONT;
  end

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .write_all_n (write_all_n),
    .lane_gate_n (lane_gate_n),
    .lane_en_n   (lane_en_n),
    .lane_we     (lane_we),
    .any_we      (any_we)
  );

  // Write enables are ignored on a processor-strobe load.
  assign wr_beat  = any_we && (((kind == EDGE_LOAD) && !proc_go) || (kind == EDGE_CONT));
  assign rd_beat  = ((kind == EDGE_LOAD) || (kind == EDGE_CONT)) && !wr_beat;
  assign step     = (kind == EDGE_CONT) && !burst_step_n;
  assign eff_addr = (kind == EDGE_LOAD) ? addr : (step ? nxt_addr : cur_addr);
  assign mem_we   = wr_beat ? lane_we : '0;

  sram_burst_seq #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (kind == EDGE_LOAD),
    .load_addr (addr),
    .step      (step),
    .linear    (linear_mode),
    .cur_addr  (cur_addr),
    .nxt_addr  (nxt_addr)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk     (clk),
    .lane_we (mem_we),
    .rd_en   (rd_beat),
    .addr    (eff_addr),
    .wdata   (wdata),
    .rdata   (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      vld1_q    <= 1'b0;
      vld2_q    <= 1'b0;
      out_q     <= '0;
      wr_hide_q <= 1'b0;
    end else begin
      wr_hide_q <= wr_beat;
      out_q     <= ram_q;
      vld2_q    <= vld1_q && !snooze;
      case (kind)
        EDGE_LOAD: begin
          active_q <= 1'b1;
          vld1_q   <= rd_beat;
        end
        EDGE_CONT:  vld1_q <= rd_beat;
        EDGE_DESEL: begin
          active_q <= 1'b0;
          vld1_q   <= 1'b0;
        end
        default: if (snooze) vld1_q <= 1'b0;
      endcase
    end
  end

  // Output selection and tristate-style qualification.
  assign sel_data  = flow_thru_n ? out_q  : ram_q;
  assign sel_vld   = flow_thru_n ? vld2_q : vld1_q;
  assign rdata_vld = sel_vld && !out_en_n && !snooze && !wr_hide_q;
  assign rdata     = rdata_vld ? sel_data : '0;

  AST_PIPE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (vld1_q && !snooze) |=> vld2_q); // R6
  AST_PROC_READS: assert property (@(posedge clk) disable iff (rst)
    ((kind == EDGE_LOAD) && proc_go) |=> vld1_q); // R4
  AST_WRITE_HIDES: assert property (@(posedge clk) disable iff (rst)
    wr_beat |=> !rdata_vld); // R9
  AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (rst)
    (kind == EDGE_DESEL) |=> (!vld1_q && !active_q)); // R10
  AST_SNOOZE_SILENT: assert property (@(posedge clk) disable iff (rst)
    snooze |=> (!vld1_q && !rdata_vld)); // R11
endmodule

// File: tb/burst_sram_ctrl_test.sv
`timescale 1ns/1ps
module burst_sram_ctrl_test;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          proc_n = 1'b1, ctrl_n = 1'b1, master_n = 1'b0, aux = 1'b1;
  logic          step_n = 1'b1, linear = 1'b1, all_n = 1'b1, gate_n = 1'b1;
  logic [LN-1:0] en_n = '1;
  logic [DW-1:0] wdata = '0;
  logic          oe_n = 1'b1, flow_n = 1'b1, snooze = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdata_vld;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #2.5 clk = ~clk;

  burst_sram_ctrl uut (
    .clk(clk), .rst(rst), .addr(addr), .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n),
    .master_sel_n(master_n), .aux_sel(aux), .burst_step_n(step_n), .linear_mode(linear),
    .write_all_n(all_n), .lane_gate_n(gate_n), .lane_en_n(en_n), .wdata(wdata),
    .out_en_n(oe_n), .flow_thru_n(flow_n), .snooze(snooze), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  // Monitor: every valid output cycle consumes one scoreboard entry.
  always @(negedge clk) begin
    if (!rst && rdata_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected output act=%h exp=none", rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s data act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    proc_n = 1'b1; ctrl_n = 1'b1; master_n = 1'b0; aux = 1'b1;
    step_n = 1'b1; all_n = 1'b1; gate_n = 1'b1; en_n = '1;
  endtask

  task automatic expect_data(input logic [DW-1:0] d, input string t);
    exp_q.push_back(d);
    tag_q.push_back(t);
  endtask

  task automatic quiet(input string t);
    #1;
    checks++;
    if (rdata_vld !== 1'b0 || rdata !== '0) begin
      failures++;
      $display("FAIL %s quiet act=%b/%h exp=0/0", t, rdata_vld, rdata);
    end
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic an, input logic gn, input logic [LN-1:0] en);
    for (int i = 0; i < LN; i++)
      if (!an || (!gn && !en[i])) model[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  task automatic cwrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic an, input logic gn, input logic [LN-1:0] en);
    addr = a; wdata = d; ctrl_n = 1'b0; all_n = an; gate_n = gn; en_n = en;
    tick();
    model_write(a, d, an, gn, en);
    idle();
  endtask

  task automatic desel();
    ctrl_n = 1'b0; aux = 1'b0;
    tick();
    idle();
  endtask

  task automatic read_pipe(input logic [AW-1:0] a, input string t);
    flow_n = 1'b1;
    desel();
    tick();
    proc_n = 1'b0; addr = a;
    tick();
    idle(); oe_n = 1'b0;
    quiet({t, " R6 not before second edge"});
    tick();
    expect_data(model[a], t);
    tick();
    oe_n = 1'b1;
  endtask

  task automatic read_flow(input logic [AW-1:0] a, input string t);
    flow_n = 1'b0;
    desel();
    proc_n = 1'b0; addr = a;
    tick();
    idle(); oe_n = 1'b0;
    expect_data(model[a], t);
    tick();
    oe_n = 1'b1;
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int n, input logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(b[1:0] + 2'(n)) : (b[1:0] ^ 2'(n));
    return {b[AW-1:2], lo};
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R12: reset state with output enabled
    oe_n = 1'b0;
    repeat (3) tick();
    quiet("R12 in reset");
    rst = 1'b0;
    tick();
    quiet("R12 after reset");
    oe_n = 1'b1;

    // R1: seed with global writes, lane controls set to no-write
    for (int a = 0; a < 16; a++)
      cwrite(AW'(a), DW'(a * 7 + 18'h12345 + (a << 10)), 1'b0, 1'b1, 2'b11);
    read_pipe(6'd3, "R1");
    read_pipe(6'd10, "R6");
    read_flow(6'd7, "R7");

    // R2: per-lane writes and the no-lane case
    cwrite(6'd4, 18'h3FFFF, 1'b1, 1'b0, 2'b10);
    read_pipe(6'd4, "R2 lane0");
    cwrite(6'd5, 18'h2AAAA, 1'b1, 1'b0, 2'b01);
    read_flow(6'd5, "R2 lane1");
    flow_n = 1'b0; desel();
    ctrl_n = 1'b0; addr = 6'd6; gate_n = 1'b0; en_n = 2'b11; wdata = 18'h15555;
    tick(); idle(); oe_n = 1'b0;
    expect_data(model[6], "R2 no lane is read");
    tick(); oe_n = 1'b1;

    // R3: gate high makes lane enables irrelevant
    desel();
    ctrl_n = 1'b0; addr = 6'd8; gate_n = 1'b1; en_n = 2'b00; wdata = 18'h0F0F0;
    tick(); idle(); oe_n = 1'b0;
    expect_data(model[8], "R3 read");
    tick(); oe_n = 1'b1;
    read_pipe(6'd8, "R3 unchanged");

    // R4: processor start ignores lane enables, next beat writes lane0
    flow_n = 1'b0; desel();
    proc_n = 1'b0; addr = 6'd2; gate_n = 1'b0; en_n = 2'b00; wdata = 18'h1F0F0;
    tick();
    proc_n = 1'b1; en_n = 2'b10; oe_n = 1'b0;
    expect_data(model[2], "R4 start is read");
    tick();
    model_write(6'd2, 18'h1F0F0, 1'b1, 1'b0, 2'b10);
    idle();
    quiet("R9 write hides output");
    tick();
    expect_data(model[2], "R4 later beat wrote");
    tick(); oe_n = 1'b1;

    // R5: controller write on its own edge; processor wins when both low
    cwrite(6'd9, 18'h0ABCD, 1'b1, 1'b0, 2'b01);
    read_pipe(6'd9, "R5 lane1 write");
    flow_n = 1'b0; desel();
    proc_n = 1'b0; ctrl_n = 1'b0; addr = 6'd11; all_n = 1'b0; wdata = '0;
    tick(); idle(); oe_n = 1'b0;
    expect_data(model[11], "R5 both strobes read");
    tick(); oe_n = 1'b1;
    read_pipe(6'd11, "R5 not written");

    // R8: write beat with step advances before writing
    desel();
    ctrl_n = 1'b0; addr = 6'd12; all_n = 1'b0; wdata = 18'h2468A;
    tick();
    model_write(6'd12, 18'h2468A, 1'b0, 1'b1, 2'b11);
    ctrl_n = 1'b1; step_n = 1'b0; wdata = 18'h13579;
    tick();
    model_write(6'd13, 18'h13579, 1'b0, 1'b1, 2'b11);
    idle();
    read_pipe(6'd13, "R8 stepped write");
    read_pipe(6'd12, "R8 first write");

    // R8: burst orders, linear then interleaved, through the wrap
    for (int m = 0; m < 2; m++) begin
      linear = (m == 0);
      flow_n = 1'b0; desel();
      proc_n = 1'b0; addr = 6'd9;
      tick(); idle(); step_n = 1'b0; oe_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
        expect_data(model[beat_addr(6'd9, i, linear)], m == 0 ? "R8 linear" : "R8 interleaved");
        tick();
      end
      step_n = 1'b1; oe_n = 1'b1;
    end
    linear = 1'b1;

    // R10: pipelined deselect drains one beat
    read_pipe(6'd1, "R10 setup");
    desel(); tick();
    proc_n = 1'b0; addr = 6'd1;
    tick(); idle();
    tick();
    ctrl_n = 1'b0; aux = 1'b0; oe_n = 1'b0;
    expect_data(model[1], "R10 before deselect");
    tick(); idle();
    expect_data(model[1], "R10 pipelined drain");
    tick();
    quiet("R10 pipelined dropped");
    oe_n = 1'b1;

    // R10: flow-through deselect drops at once
    flow_n = 1'b0; desel();
    proc_n = 1'b0; addr = 6'd1;
    tick(); idle();
    ctrl_n = 1'b0; aux = 1'b0; oe_n = 1'b0;
    expect_data(model[1], "R10 flow before deselect");
    tick(); idle();
    quiet("R10 flow dropped");
    oe_n = 1'b1;

    // R10: master enable blocks processor strobe, not controller strobe
    desel();
    proc_n = 1'b0; addr = 6'd1;
    tick(); idle();
    master_n = 1'b1; proc_n = 1'b0; addr = 6'd14; oe_n = 1'b0;
    expect_data(model[1], "R10 before blocked edge");
    tick(); idle();
    expect_data(model[1], "R10 blocked edge holds");
    tick();
    expect_data(model[1], "R10 burst kept address");
    master_n = 1'b1; ctrl_n = 1'b0;
    tick(); idle();
    quiet("R10 controller strobe deselects");
    oe_n = 1'b1;

    // R11: snooze blocks a write and the output, contents kept
    flow_n = 1'b0; desel();
    proc_n = 1'b0; addr = 6'd3;
    tick(); idle();
    snooze = 1'b1; ctrl_n = 1'b0; addr = 6'd3; all_n = 1'b0; wdata = ~model[3]; oe_n = 1'b0;
    quiet("R11 output off");
    tick();
    quiet("R11 output off after edge");
    tick();
    snooze = 1'b0; idle();
    quiet("R11 no read during snooze");
    tick();
    expect_data(model[3], "R11 contents kept");
    tick(); oe_n = 1'b1;

    repeat (3) tick();
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9 scoreboard act=%0d pending exp=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule